// File: doc/BRIEF.md
# Panning Frame Buffer Address Generator

This block turns display timing strobes into a stream of memory word addresses for a frame buffer that shows a window of a wider virtual screen. Software programs a start location as a 7-bit bank and a 21-bit half-word offset. It also programs how many half-words each displayed line holds, how many half-words to skip between the end of one displayed line and the start of the next, and the half-word offset at which the frame ends. Changing the start offset and the skip lets the visible window pan across the virtual screen.

A timing generator pulses `frame_start` once per frame and `line_start` once per line. It then requests fetches on a valid/ready handshake. Each accepted fetch places one word address into a single-entry output register. That register is drained on a second valid/ready handshake. Back-pressure works as follows: `addr_valid` and `addr_word` hold steady while `addr_ready` is low, and `fetch_ready` stays low while the output register is full and not being drained. A separate combinational read-data path passes returned words through with optional half-word and byte reordering. On that path `px_valid` follows `rd_valid` and `rd_ready` follows `px_ready`.

Offsets count half-words and address bit 1 is the lowest offset bit. The start offset and the skip are expected to be even. The word address is the bank followed by offset bits [20:1].

Top module: `vsfa_top`

## Requirements
- R1: After reset `addr_valid` is 0, `frame_done` is 1 and `fetch_ready` is 0.
- R2: A `frame_start` pulse loads the cursor from `cfg_base` and clears `frame_done` in the next cycle. The first fetch of the frame returns `{cfg_bank, cfg_base[20:1]}`.
- R3: Each accepted fetch (`fetch_valid` and `fetch_ready` high at a clock edge) emits the current word address and advances the cursor by two half-words, so consecutive fetches give consecutive word addresses.
- R4: The first `line_start` after `frame_start` leaves the cursor unchanged. Every later `line_start` adds `cfg_skip` half-words to it.
- R5: The cursor wraps modulo 2^21 half-words, and the upper 7 bits of `addr_word` (bits [26:20]) always equal `cfg_bank`.
- R6: Once a line has consumed `cfg_width` half-words, `fetch_ready` stays low until the next `line_start` or `frame_start`.
- R7: When an accepted fetch completes a line, and the cursor after it plus `cfg_skip` equals `cfg_end`, `frame_done` rises. It then stays high and blocks all fetches until the next `frame_start`.
- R8: In a cycle with `frame_start` or `line_start` high, `fetch_ready` is 0 and no fetch is taken.
- R9: While `addr_valid` is 1 and `addr_ready` is 0, `addr_word` holds and `fetch_ready` is 0.
- R10: `px_data` reorders `rd_data`. With `cfg_hw_swap`=1 the two 16-bit halves are exchanged. With `cfg_byte_swap`=1 the bytes inside each 16-bit half are exchanged. With both set, the halves are exchanged first and the bytes second, so 0x11223344 becomes 0x44332211.
- R11: `px_valid` equals `rd_valid` and `rd_ready` equals `px_ready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bank | input | 7 | Bank bits placed above the offset |
| cfg_base | input | 21 | Start half-word offset |
| cfg_width | input | 11 | Half-words displayed per line |
| cfg_skip | input | 11 | Half-words skipped between lines |
| cfg_end | input | 21 | Half-word offset marking the frame end |
| cfg_hw_swap | input | 1 | Exchange 16-bit halves of read data |
| cfg_byte_swap | input | 1 | Exchange bytes inside each 16-bit half |
| frame_start | input | 1 | Frame start strobe |
| line_start | input | 1 | Line start strobe |
| fetch_valid | input | 1 | Fetch request |
| fetch_ready | output | 1 | Fetch can be taken this cycle |
| addr_valid | output | 1 | Word address available |
| addr_ready | input | 1 | Consumer takes the word address |
| addr_word | output | 27 | Word address {bank, offset[20:1]} |
| frame_done | output | 1 | Frame end reached |
| rd_valid | input | 1 | Returned data valid |
| rd_ready | output | 1 | Returned data accepted |
| rd_data | input | 32 | Returned data word |
| px_valid | output | 1 | Reordered data valid |
| px_ready | input | 1 | Downstream accepts reordered data |
| px_data | output | 32 | Reordered data word |

## Verification
A fetch request can arrive in the same cycle as a line or frame strobe, and the two would then move the cursor in conflicting ways. The bench raises `fetch_valid` together with `line_start`, and later together with `frame_start`. In each case it checks that `fetch_ready` is low in that cycle. It then checks through the scoreboard that the next emitted address already includes the skip or the reload. A second overlap, a fetch that is being held back while the output register is stalled, is provoked by holding `addr_ready` low. In that case the held address and the blocked request are both checked.

// File: rtl/vsfa_pkg.sv
package vsfa_pkg;
  typedef enum logic [2:0] {
    STEP_IDLE,
    STEP_LOAD,
    STEP_FIRST,
    STEP_SKIP,
    STEP_ADVANCE
  } step_e;
endpackage

// File: rtl/vsfa_cursor.sv
module vsfa_cursor
  import vsfa_pkg::*;
#(
  parameter int OFS_W  = 21,
  parameter int SPAN_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              take,
  input  logic [OFS_W-1:0]  base,
  input  logic [SPAN_W-1:0] width,
  input  logic [SPAN_W-1:0] skip,
  input  logic [OFS_W-1:0]  end_ofs,
  output logic [OFS_W-1:0]  cur,
  output logic              line_full,
  output logic              done
);
  localparam int CNT_W = SPAN_W + 1;

  step_e             step;
  logic              first_line;
  logic [CNT_W-1:0]  line_cnt;
  logic [CNT_W-1:0]  cnt_next;
  logic [OFS_W-1:0]  cur_next;
  logic [OFS_W-1:0]  projected;
  logic              completes_line;

  always_comb begin
    if (frame_start)     step = STEP_LOAD;
    else if (line_start) step = first_line ? STEP_FIRST : STEP_SKIP;
    else if (take)       step = STEP_ADVANCE;
    else                 step = STEP_IDLE;
  end

  assign cnt_next       = line_cnt + CNT_W'(2);
  assign cur_next       = cur + OFS_W'(2);
  assign projected      = cur_next + OFS_W'(skip);
  assign completes_line = (cnt_next >= {1'b0, width});
  assign line_full      = (line_cnt >= {1'b0, width});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur        <= '0;
      line_cnt   <= '0;
      first_line <= 1'b1;
      done       <= 1'b1;
    end else begin
      case (step)
        STEP_LOAD: begin
          cur        <= base;
          line_cnt   <= '0;
          first_line <= 1'b1;
          done       <= 1'b0;
        end
        STEP_FIRST: begin
          line_cnt   <= '0;
          first_line <= 1'b0;
        end
        STEP_SKIP: begin
          cur      <= cur + OFS_W'(skip);
          line_cnt <= '0;
        end
        STEP_ADVANCE: begin
          cur      <= cur_next;
          line_cnt <= cnt_next;
          if (completes_line && (projected == end_ofs)) done <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vsfa_slot.sv
module vsfa_slot #(
  parameter int AW = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= in_addr;
    end
  end
endmodule

// File: rtl/vsfa_swap.sv
module vsfa_swap #(
  parameter int DATA_W = 32
) (
  input  logic              hw_swap,
  input  logic              byte_swap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int HALF_W = DATA_W / 2;
  localparam int N16    = DATA_W / 16;

  logic [DATA_W-1:0] stage1;

  assign stage1 = hw_swap ? {din[HALF_W-1:0], din[DATA_W-1:HALF_W]} : din;

  for (genvar g = 0; g < N16; g++) begin : g_lane
    assign dout[g*16 +: 16] = byte_swap ? {stage1[g*16 +: 8], stage1[g*16+8 +: 8]}
                                        : stage1[g*16 +: 16];
  end
endmodule

// File: rtl/vsfa_top.sv
module vsfa_top #(
  parameter int BANK_W = 7,
  parameter int OFS_W  = 21,
  parameter int SPAN_W = 11,
  parameter int DATA_W = 32,
  localparam int AW    = BANK_W + OFS_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [OFS_W-1:0]  cfg_base,
  input  logic [SPAN_W-1:0] cfg_width,
  input  logic [SPAN_W-1:0] cfg_skip,
  input  logic [OFS_W-1:0]  cfg_end,
  input  logic              cfg_hw_swap,
  input  logic              cfg_byte_swap,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [AW-1:0]     addr_word,
  output logic              frame_done,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [DATA_W-1:0] px_data
);
  logic [OFS_W-1:0] cur;
  logic             line_full;
  logic             slot_ready;
  logic             take;
  logic [AW-1:0]    next_word;

  assign fetch_ready = slot_ready && !frame_done && !line_full && !frame_start && !line_start;
  assign take        = fetch_valid && fetch_ready;
  assign next_word   = {cfg_bank, cur[OFS_W-1:1]};

  vsfa_cursor #(.OFS_W(OFS_W), .SPAN_W(SPAN_W)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .line_start (line_start),
    .take       (take),
    .base       (cfg_base),
    .width      (cfg_width),
    .skip       (cfg_skip),
    .end_ofs    (cfg_end),
    .cur        (cur),
    .line_full  (line_full),
    .done       (frame_done)
  );

  vsfa_slot #(.AW(AW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (take),
    .in_ready (slot_ready),
    .in_addr  (next_word),
    .out_valid(addr_valid),
    .out_ready(addr_ready),
    .out_addr (addr_word)
  );

  vsfa_swap #(.DATA_W(DATA_W)) u_swap (
    .hw_swap  (cfg_hw_swap),
    .byte_swap(cfg_byte_swap),
    .din      (rd_data),
    .dout     (px_data)
  );

  assign px_valid = rd_valid;
  assign rd_ready = px_ready;
endmodule

// File: rtl/vsfa_checker.sv
module vsfa_checker #(
  parameter int BANK_W = 7,
  parameter int DATA_W = 32,
  parameter int AW     = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BANK_W-1:0] cfg_bank,
  input logic              cfg_hw_swap,
  input logic              cfg_byte_swap,
  input logic              frame_start,
  input logic              line_start,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [AW-1:0]     addr_word,
  input logic              frame_done,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] px_data
);
  AST_DONE_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !fetch_ready);  // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_start) |=> frame_done);  // R7
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_done);  // R2
  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start || line_start) |-> !fetch_ready);  // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_word)));  // R9
  AST_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> (addr_valid && addr_word[AW-1 -: BANK_W] == $past(cfg_bank)));  // R5
  AST_SWAP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hw_swap && !cfg_byte_swap) |-> (px_data == rd_data));  // R10
endmodule

bind vsfa_top vsfa_checker #(.BANK_W(BANK_W), .DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_bank     (cfg_bank),
  .cfg_hw_swap  (cfg_hw_swap),
  .cfg_byte_swap(cfg_byte_swap),
  .frame_start  (frame_start),
  .line_start   (line_start),
  .fetch_valid  (fetch_valid),
  .fetch_ready  (fetch_ready),
  .addr_valid   (addr_valid),
  .addr_ready   (addr_ready),
  .addr_word    (addr_word),
  .frame_done   (frame_done),
  .rd_data      (rd_data),
  .px_data      (px_data)
);

// File: tb/sim_vsfa_top.sv
`timescale 1ns/1ps
module sim_vsfa_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cfg_bank = '0;
  logic [20:0] cfg_base = '0;
  logic [10:0] cfg_width = '0;
  logic [10:0] cfg_skip = '0;
  logic [20:0] cfg_end = '0;
  logic        cfg_hw_swap = 1'b0;
  logic        cfg_byte_swap = 1'b0;
  logic        frame_start = 1'b0;
  logic        line_start = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic        addr_valid;
  logic        addr_ready = 1'b1;
  logic [26:0] addr_word;
  logic        frame_done;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [31:0] rd_data = '0;
  logic        px_valid;
  logic        px_ready = 1'b0;
  logic [31:0] px_data;

  int total = 0;
  int bad = 0;
  logic [26:0] exp_q[$];
  logic [20:0] mcur;
  logic        mfirst;
  logic [26:0] held;

  always #4 clk = ~clk;

  vsfa_top u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_frame();
    frame_start = 1'b1;
    mcur = cfg_base;
    mfirst = 1'b1;
    cycle();
    frame_start = 1'b0;
  endtask

  task automatic pulse_line();
    line_start = 1'b1;
    if (mfirst) mfirst = 1'b0;
    else mcur = mcur + 21'(cfg_skip);
    cycle();
    line_start = 1'b0;
  endtask

  // driver: pushes expected word addresses into the scoreboard
  task automatic fetch_words(input int n);
    for (int i = 0; i < n; i++) begin
      fetch_valid = 1'b1;
      @(negedge clk);
      while (!fetch_ready) @(negedge clk);
      exp_q.push_back({cfg_bank, mcur[20:1]});
      mcur = mcur + 21'd2;
      cycle();
    end
    fetch_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) cycle();
  endtask

  // monitor: pops and compares on each output handshake
  always @(negedge clk) begin
    if (rst_n && addr_valid && addr_ready) begin
      if (exp_q.size() == 0) chk("R3 unexpected address", {5'd0, addr_word}, 32'hFFFF_FFFF);
      else chk("R3/R5 scoreboard address", {5'd0, addr_word}, {5'd0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mcur = '0;
    mfirst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr_valid", {31'd0, addr_valid}, 32'd0);
    chk("R1 frame_done", {31'd0, frame_done}, 32'd1);
    chk("R1 fetch_ready", {31'd0, fetch_ready}, 32'd0);
    cycle();

    // two-line frame ending exactly at cfg_end
    cfg_bank = 7'h15; cfg_base = 21'h100; cfg_width = 11'd4; cfg_skip = 11'd6; cfg_end = 21'h114;
    pulse_frame();
    @(negedge clk);
    chk("R2 done cleared", {31'd0, frame_done}, 32'd0);
    cycle();
    pulse_line();
    fetch_words(2);
    drain();
    @(negedge clk);
    chk("R6 line full blocks fetch", {31'd0, fetch_ready}, 32'd0);
    chk("R7 not done after line 1", {31'd0, frame_done}, 32'd0);
    cycle();
    pulse_line();
    fetch_words(2);
    drain();
    @(negedge clk);
    chk("R7 done at end", {31'd0, frame_done}, 32'd1);
    cycle();
    pulse_line();
    @(negedge clk);
    chk("R7 done still blocks", {31'd0, fetch_ready}, 32'd0);
    cycle();

    // wrap of the offset, bank untouched
    cfg_bank = 7'h7F; cfg_base = 21'h1FFFFC; cfg_width = 11'd8; cfg_skip = 11'd0; cfg_end = 21'h000100;
    pulse_frame();
    pulse_line();
    fetch_words(4);
    drain();
    chk("R5 wrap scoreboard empty", exp_q.size(), 32'd0);

    // strobe and fetch in the same cycle
    cfg_bank = 7'h03; cfg_base = 21'h40; cfg_width = 11'd16; cfg_skip = 11'd10; cfg_end = 21'h1F0000;
    pulse_frame();
    pulse_line();
    fetch_words(1);
    fetch_valid = 1'b1;
    line_start = 1'b1;
    @(negedge clk);
    chk("R8 line_start beats fetch", {31'd0, fetch_ready}, 32'd0);
    cycle();
    line_start = 1'b0;
    mcur = mcur + 21'(cfg_skip);
    fetch_words(1);
    drain();
    cfg_base = 21'h80;
    fetch_valid = 1'b1;
    frame_start = 1'b1;
    @(negedge clk);
    chk("R8 frame_start beats fetch", {31'd0, fetch_ready}, 32'd0);
    cycle();
    frame_start = 1'b0;
    fetch_valid = 1'b0;
    mcur = cfg_base;
    mfirst = 1'b1;
    pulse_line();
    fetch_words(1);
    drain();
    chk("R4 R8 scoreboard empty", exp_q.size(), 32'd0);

    // back-pressure on the address output
    addr_ready = 1'b0;
    fetch_words(1);
    fetch_valid = 1'b1;
    @(negedge clk);
    chk("R9 stalled slot blocks fetch", {31'd0, fetch_ready}, 32'd0);
    held = addr_word;
    repeat (3) cycle();
    @(negedge clk);
    chk("R9 addr held", {5'd0, addr_word}, {5'd0, held});
    chk("R9 valid held", {31'd0, addr_valid}, 32'd1);
    cycle();
    fetch_valid = 1'b0;
    addr_ready = 1'b1;
    drain();

    // read data path
    rd_valid = 1'b1; px_ready = 1'b0; rd_data = 32'h11223344;
    cfg_hw_swap = 1'b0; cfg_byte_swap = 1'b0;
    @(negedge clk);
    chk("R11 px_valid", {31'd0, px_valid}, 32'd1);
    chk("R11 rd_ready low", {31'd0, rd_ready}, 32'd0);
    chk("R10 no swap", px_data, 32'h11223344);
    cycle();
    px_ready = 1'b1; cfg_hw_swap = 1'b1;
    @(negedge clk);
    chk("R11 rd_ready high", {31'd0, rd_ready}, 32'd1);
    chk("R10 half swap", px_data, 32'h33441122);
    cycle();
    cfg_hw_swap = 1'b0; cfg_byte_swap = 1'b1;
    @(negedge clk);
    chk("R10 byte swap", px_data, 32'h22114433);
    cycle();
    cfg_hw_swap = 1'b1;
    @(negedge clk);
    chk("R10 both swaps", px_data, 32'h44332211);
    cycle();
    rd_valid = 1'b0;
    @(negedge clk);
    chk("R11 px_valid low", {31'd0, px_valid}, 32'd0);

    chk("R3 scoreboard drained", exp_q.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule